// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Interface

This block is the digital front end of a four-channel, 12-bit converter. Every channel keeps two registers: an input rank that collects incoming data and an output rank that feeds the converter core. A host picks a channel with a 2-bit address and writes data while the chip-select and latch-select strobes are both low. The output rank changes only when latch-select rises while chip-select is still low. If chip-select is released first, the new word stays parked in the input rank. This lets software preload all four channels and then update them one by one.

Every control pin is active low and is sampled on the rising system clock. The block finds strobe edges by comparing each sample with the one taken before it. A slice-select field lets a narrow host bus write nibbles or bytes instead of the whole word. Other controls provide a pass-through mode that loads both ranks at once, a small mode register, a readback path for the output ranks and the mode register, and a clear input that overrides everything else.

Top module: `qdac_regs`

## Requirements
- R1: `chanSel` 00, 01, 10, 11 addresses channels A, B, C, D. The output rank of channel i appears on `rankOut[12*i+11:12*i]`.
- R2: A sample with `csN`=0, `lsN`=0 and `rdN`, `trN`, `msN`, `clrN` all 1 writes the data slice into the addressed input rank. No output rank changes.
- R3: A sample with `lsN`=1, taken while `csN`=0 and `rdN`, `trN`, `msN`, `clrN` are 1, copies the addressed input rank into its output rank, provided the previous sample had `lsN`=0.
- R4: When `csN` rises before `lsN`, the output rank keeps its old value and the input rank keeps the preloaded word.
- R5: `quadSel` chooses which part of the word is written. 000 writes the whole word from `dataIn[11:0]`. 001, 010 and 011 write bits [3:0], [7:4] and [11:8] from `dataIn[3:0]`. 100 writes bits [7:0] from `dataIn[7:0]`. 101 writes bits [11:4] from `dataIn[7:0]`. 110 and 111 act as 000. Bits outside the chosen slice keep their value.
- R6: With `csN`=0, `trN`=0 and `rdN`=1, and not the R7 case, both ranks load the merged word. If `lsN`=1 this happens in all four channels. If `lsN`=0 it happens only in the addressed channel.
- R7: With `csN`, `msN`, `trN`, `lsN` all 0 and `rdN`=1, the 8-bit mode register loads `dataIn[7:0]` and no rank changes.
- R8: With `csN`=0 and `rdN`=0, `rbOe` is 1. `rbData` shows the addressed output rank when `msN`=1, or the mode register zero-extended when `msN`=0. No register changes during readback.
- R9: Outside readback, `rbOe` is 0 and `rbData` is 0.
- R10: A sample with `clrN`=0 zeroes all ranks and the mode register, whatever the other inputs are.
- R11: `rstN` low zeroes all ranks and the mode register, and holds `rbOe` at 0.
- R12: A pin sample takes effect on the registers at the following clock edge. Readback follows the sample directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| csN | input | 1 | Chip select, active low |
| lsN | input | 1 | Latch select strobe, active low |
| rdN | input | 1 | Readback request, active low |
| trN | input | 1 | Pass-through control, active low |
| msN | input | 1 | Mode control, active low |
| clrN | input | 1 | Register clear, active low |
| chanSel | input | 2 | Channel address |
| quadSel | input | 3 | Slice select |
| dataIn | input | 12 | Write data bus |
| rankOut | output | 48 | Four output-rank words, channel A lowest |
| rbData | output | 12 | Readback bus |
| rbOe | output | 1 | Readback output enable |

## Verification
The assertions assume that at most one strobe comes out of the decoder in each cycle, and that the address held with a transfer strobe is the one whose input rank is copied. The assertions also rely on the control pins being stable for a whole clock cycle, because each value is sampled once. The stimulus changes pins only on the falling clock edge. It holds each combination for one full period, and it weights the random draws so that ordinary loads and transfers are common, while clears, readbacks, pass-through and mode writes are occasional.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  // one registered sample of the active-low control pins
  typedef struct packed {
    logic csN;
    logic lsN;
    logic rdN;
    logic trN;
    logic msN;
    logic clrN;
  } pinSample_t;

  // strobes from control to datapath; at most one is set per cycle
  typedef struct packed {
    logic clrAll;
    logic wrIn;
    logic xfer;
    logic transAll;
    logic transOne;
    logic modeWr;
    logic rbOe;
    logic rbMode;
  } rankStrobe_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int AddrW = 2,
  parameter int QuadW = 3,
  parameter int DataW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             lsN,
  input  logic             rdN,
  input  logic             trN,
  input  logic             msN,
  input  logic             clrN,
  input  logic [AddrW-1:0] chanSel,
  input  logic [QuadW-1:0] quadSel,
  input  logic [DataW-1:0] dataIn,
  output rankStrobe_t      stb,
  output logic [AddrW-1:0] selAddr,
  output logic [QuadW-1:0] selQuad,
  output logic [DataW-1:0] selData
);
  pinSample_t smp;
  logic       prevLs;

  // sample all pins; idle state is every control high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smp     <= '{csN: 1'b1, lsN: 1'b1, rdN: 1'b1, trN: 1'b1, msN: 1'b1, clrN: 1'b1};
      prevLs  <= 1'b1;
      selAddr <= '0;
      selQuad <= '0;
      selData <= '0;
    end else begin
      smp     <= '{csN: csN, lsN: lsN, rdN: rdN, trN: trN, msN: msN, clrN: clrN};
      prevLs  <= smp.lsN;
      selAddr <= chanSel;
      selQuad <= quadSel;
      selData <= dataIn;
    end
  end

  // priority: clear, readback, mode write, pass-through, normal load/transfer
  always_comb begin
    stb = '0;
    if (!smp.clrN) begin
      stb.clrAll = 1'b1;
    end else if (!smp.csN) begin
      if (!smp.rdN) begin
        stb.rbOe   = 1'b1;
        stb.rbMode = !smp.msN;
      end else if (!smp.msN && !smp.trN && !smp.lsN) begin
        stb.modeWr = 1'b1;
      end else if (!smp.trN) begin
        if (smp.lsN) stb.transAll = 1'b1;
        else         stb.transOne = 1'b1;
      end else if (smp.msN) begin
        if (!smp.lsN)      stb.wrIn = 1'b1;
        else if (!prevLs)  stb.xfer = 1'b1;
      end
    end
  end
endmodule

// File: rtl/qdac_data.sv
module qdac_data
  import qdac_pkg::*;
#(
  parameter int AddrW = 2,
  parameter int QuadW = 3,
  parameter int DataW = 12,
  parameter int ModeW = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rankStrobe_t                  stb,
  input  logic [AddrW-1:0]             selAddr,
  input  logic [QuadW-1:0]             selQuad,
  input  logic [DataW-1:0]             selData,
  output logic [(1<<AddrW)*DataW-1:0]  outFlat,
  output logic [DataW-1:0]             rbData,
  output logic                         rbOe
);
  localparam int NumCh = 1 << AddrW;
  localparam int NibW  = DataW / 3;
  localparam int ByteW = 2 * NibW;

  logic [NumCh-1:0][DataW-1:0] inRank;
  logic [NumCh-1:0][DataW-1:0] outRank;
  logic [NumCh-1:0][DataW-1:0] merged;
  logic [ModeW-1:0]            modeReg;

  function automatic logic [DataW-1:0] mergeSlice(
    input logic [DataW-1:0] old,
    input logic [DataW-1:0] din,
    input logic [QuadW-1:0] q
  );
    logic [DataW-1:0] r;
    r = old;
    case (q)
      QuadW'(1): r[NibW-1:0]          = din[NibW-1:0];
      QuadW'(2): r[2*NibW-1:NibW]     = din[NibW-1:0];
      QuadW'(3): r[3*NibW-1:2*NibW]   = din[NibW-1:0];
      QuadW'(4): r[ByteW-1:0]         = din[ByteW-1:0];
      QuadW'(5): r[DataW-1:DataW-ByteW] = din[ByteW-1:0];
      default:   r = din;
    endcase
    return r;
  endfunction

  for (genvar i = 0; i < NumCh; i++) begin : gChan
    logic hit;
    assign hit = (selAddr == AddrW'(i));
    assign merged[i] = mergeSlice(inRank[i], selData, selQuad);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inRank[i]  <= '0;
        outRank[i] <= '0;
      end else if (stb.clrAll) begin
        inRank[i]  <= '0;
        outRank[i] <= '0;
      end else if (stb.transAll || (stb.transOne && hit)) begin
        inRank[i]  <= merged[i];
        outRank[i] <= merged[i];
      end else if (stb.wrIn && hit) begin
        inRank[i]  <= merged[i];
      end else if (stb.xfer && hit) begin
        outRank[i] <= inRank[i];
      end
    end

    assign outFlat[i*DataW +: DataW] = outRank[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            modeReg <= '0;
    else if (stb.clrAll)  modeReg <= '0;
    else if (stb.modeWr)  modeReg <= selData[ModeW-1:0];
  end

  always_comb begin
    rbOe   = stb.rbOe;
    rbData = '0;
    if (stb.rbOe) rbData = stb.rbMode ? DataW'(modeReg) : outRank[selAddr];
  end

  // output ranks hold unless a strobe that may touch them is present (R4)
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.xfer || stb.transAll || stb.transOne || stb.clrAll) |=> $stable(outRank));

  // transfer copies the addressed input rank (R3)
  assert_xfer_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.xfer |=> outRank[$past(selAddr)] == $past(inRank[selAddr]));

  // mode write leaves every rank alone (R7)
  assert_mode_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.modeWr |=> $stable(inRank) && $stable(outRank));

  // readback disturbs no register (R8)
  assert_rb_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.rbOe |=> $stable(inRank) && $stable(outRank) && $stable(modeReg));

  // clear empties everything (R10)
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAll |=> (outRank == '0) && (inRank == '0) && (modeReg == '0));

  // a plain write leaves the output ranks untouched (R2)
  assert_write_no_out_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrIn |=> $stable(outRank));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
#(
  parameter int AddrW = 2,
  parameter int QuadW = 3,
  parameter int DataW = 12,
  parameter int ModeW = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        csN,
  input  logic                        lsN,
  input  logic                        rdN,
  input  logic                        trN,
  input  logic                        msN,
  input  logic                        clrN,
  input  logic [AddrW-1:0]            chanSel,
  input  logic [QuadW-1:0]            quadSel,
  input  logic [DataW-1:0]            dataIn,
  output logic [(1<<AddrW)*DataW-1:0] rankOut,
  output logic [DataW-1:0]            rbData,
  output logic                        rbOe
);
  rankStrobe_t      stb;
  logic [AddrW-1:0] selAddr;
  logic [QuadW-1:0] selQuad;
  logic [DataW-1:0] selData;

  qdac_ctrl #(.AddrW(AddrW), .QuadW(QuadW), .DataW(DataW)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .lsN(lsN), .rdN(rdN), .trN(trN),
    .msN(msN), .clrN(clrN), .chanSel(chanSel), .quadSel(quadSel),
    .dataIn(dataIn), .stb(stb), .selAddr(selAddr), .selQuad(selQuad),
    .selData(selData)
  );

  qdac_data #(.AddrW(AddrW), .QuadW(QuadW), .DataW(DataW), .ModeW(ModeW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .selAddr(selAddr), .selQuad(selQuad),
    .selData(selData), .outFlat(rankOut), .rbData(rbData), .rbOe(rbOe)
  );

  // readback bus is quiet whenever the enable is low (R9)
  assert_rb_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rbOe |-> rbData == '0);

  // a readback cycle follows a sampled chip select (R8)
  assert_rb_needs_cs_R8: assert property (@(posedge clk) disable iff (!rstN)
    rbOe |-> $past(!csN && !rdN && clrN));
endmodule

// File: tb/qdac_regs_test.sv
module qdac_regs_test;
  localparam int ClkPeriod = 10;

  typedef struct packed {
    logic cs, ls, rd, tr, ms, clr;
    logic [1:0]  addr;
    logic [2:0]  q;
    logic [11:0] d;
  } op_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN, lsN, rdN, trN, msN, clrN;
  logic [1:0]  chanSel;
  logic [2:0]  quadSel;
  logic [11:0] dataIn;
  logic [47:0] rankOut;
  logic [11:0] rbData;
  logic        rbOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [11:0] mIn [4];
  logic [11:0] mOut [4];
  logic [7:0]  mMode;
  logic        mPrevLs;
  op_t         pend;
  string       tagD1, tagD2;

  always #(ClkPeriod/2) clk = ~clk;

  qdac_regs uut (
    .clk(clk), .rstN(rstN), .csN(csN), .lsN(lsN), .rdN(rdN), .trN(trN),
    .msN(msN), .clrN(clrN), .chanSel(chanSel), .quadSel(quadSel),
    .dataIn(dataIn), .rankOut(rankOut), .rbData(rbData), .rbOe(rbOe)
  );

  function automatic op_t mkOp(logic cs, logic ls, logic rd, logic tr,
                               logic ms, logic clr, logic [1:0] a,
                               logic [2:0] q, logic [11:0] d);
    op_t o;
    o.cs = cs; o.ls = ls; o.rd = rd; o.tr = tr; o.ms = ms; o.clr = clr;
    o.addr = a; o.q = q; o.d = d;
    return o;
  endfunction

  function automatic op_t idleOp();
    return mkOp(1, 1, 1, 1, 1, 1, 2'd0, 3'd0, 12'h000);
  endfunction

  // slice merge per R5
  function automatic logic [11:0] slice(logic [11:0] old, logic [11:0] d, logic [2:0] q);
    logic [11:0] r = old;
    case (q)
      3'd1: r[3:0]  = d[3:0];
      3'd2: r[7:4]  = d[3:0];
      3'd3: r[11:8] = d[3:0];
      3'd4: r[7:0]  = d[7:0];
      3'd5: r[11:4] = d[7:0];
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic string tagOf(op_t o);
    if (!o.clr) return "R10";
    if (o.cs) return "R4";
    if (!o.rd) return "R8";
    if (!o.ms && !o.tr && !o.ls) return "R7";
    if (!o.tr) return "R6";
    if (!o.ls) return (o.q != 3'd0) ? "R5" : "R2";
    return "R3";
  endfunction

  function automatic logic [47:0] modelFlat();
    return {mOut[3], mOut[2], mOut[1], mOut[0]};
  endfunction

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model of the register effects from the requirements
  task automatic applyOp(op_t o);
    if (!o.clr) begin
      for (int i = 0; i < 4; i++) begin mIn[i] = '0; mOut[i] = '0; end
      mMode = '0;
    end else if (!o.cs && o.rd) begin
      if (!o.ms && !o.tr && !o.ls) mMode = o.d[7:0];
      else if (!o.tr) begin
        for (int i = 0; i < 4; i++)
          if (o.ls || o.addr == 2'(i)) begin
            mIn[i]  = slice(mIn[i], o.d, o.q);
            mOut[i] = mIn[i];
          end
      end else if (o.ms) begin
        if (!o.ls) mIn[o.addr] = slice(mIn[o.addr], o.d, o.q);
        else if (!mPrevLs) mOut[o.addr] = mIn[o.addr];
      end
    end
    mPrevLs = o.ls;
  endtask

  // called at a falling edge; ranks lag two steps, readback one (R12)
  task automatic step(op_t o);
    logic        expOe;
    logic [11:0] expRb;
    check(tagD2, rankOut, modelFlat());
    expOe = pend.clr && !pend.cs && !pend.rd;
    expRb = !expOe ? 12'h000 : (!pend.ms ? {4'h0, mMode} : mOut[pend.addr]);
    check(expOe ? "R8" : "R9", {35'd0, rbOe, rbData}, {35'd0, expOe, expRb});
    applyOp(pend);
    tagD2 = tagD1;
    tagD1 = tagOf(pend);
    pend = o;
    csN = o.cs; lsN = o.ls; rdN = o.rd; trN = o.tr; msN = o.ms; clrN = o.clr;
    chanSel = o.addr; quadSel = o.q; dataIn = o.d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(idleOp());
  endtask

  task automatic loadUpdate(logic [1:0] a, logic [11:0] d);
    step(mkOp(0, 0, 1, 1, 1, 1, a, 3'd0, d));
    step(mkOp(0, 1, 1, 1, 1, 1, a, 3'd0, d));
    step(idleOp());
  endtask

  initial begin
    #(ClkPeriod * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    op_t o;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin mIn[i] = '0; mOut[i] = '0; end
    mMode = '0; mPrevLs = 1'b1;
    pend = idleOp(); tagD1 = "R11"; tagD2 = "R11";
    o = idleOp();
    csN = o.cs; lsN = o.ls; rdN = o.rd; trN = o.tr; msN = o.ms; clrN = o.clr;
    chanSel = 0; quadSel = 0; dataIn = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {rankOut, 3'd0, rbOe, rbData}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: each address lands in its own channel slot
    loadUpdate(2'd0, 12'hA11);
    loadUpdate(2'd1, 12'hB22);
    loadUpdate(2'd2, 12'hC33);
    loadUpdate(2'd3, 12'hD44);
    idle(2);
    check("R1", rankOut, {12'hD44, 12'hC33, 12'hB22, 12'hA11});

    // R4: preload channel C, chip select released before latch select
    step(mkOp(0, 0, 1, 1, 1, 1, 2'd2, 3'd0, 12'h5E5));
    step(mkOp(1, 0, 1, 1, 1, 1, 2'd2, 3'd0, 12'h5E5));
    step(mkOp(1, 1, 1, 1, 1, 1, 2'd2, 3'd0, 12'h5E5));
    idle(2);
    check("R4", {36'd0, rankOut[35:24]}, {36'd0, 12'hC33});
    // R3: a later ls rise with cs low moves the parked word
    step(mkOp(0, 0, 1, 1, 1, 1, 2'd2, 3'd1, 12'h005)); // low nibble unchanged value
    step(mkOp(0, 1, 1, 1, 1, 1, 2'd2, 3'd0, 12'h000));
    idle(2);
    check("R3", {36'd0, rankOut[35:24]}, {36'd0, 12'h5E5});

    // R5: byte and nibble slices on channel B
    step(mkOp(0, 0, 1, 1, 1, 1, 2'd1, 3'd4, 12'h0CD));
    step(mkOp(0, 0, 1, 1, 1, 1, 2'd1, 3'd3, 12'h009));
    step(mkOp(0, 1, 1, 1, 1, 1, 2'd1, 3'd0, 12'h000));
    idle(2);
    check("R5", {36'd0, rankOut[23:12]}, {36'd0, 12'h9CD});
    step(mkOp(0, 0, 1, 1, 1, 1, 2'd1, 3'd5, 12'h0F7));
    step(mkOp(0, 0, 1, 1, 1, 1, 2'd1, 3'd2, 12'h003));
    step(mkOp(0, 1, 1, 1, 1, 1, 2'd1, 3'd0, 12'h000));
    idle(2);
    check("R5", {36'd0, rankOut[23:12]}, {36'd0, 12'hF3D});

    // R6: pass-through to all, then to one channel
    step(mkOp(0, 1, 1, 0, 1, 1, 2'd0, 3'd0, 12'h777));
    idle(2);
    check("R6", rankOut, {4{12'h777}});
    step(mkOp(0, 0, 1, 0, 1, 1, 2'd3, 3'd0, 12'h123));
    idle(2);
    check("R6", rankOut, {12'h123, {3{12'h777}}});

    // R7 and R8: mode write, then read mode and a channel back
    step(mkOp(0, 0, 1, 0, 0, 1, 2'd1, 3'd0, 12'hF5A));
    idle(2);
    check("R7", rankOut, {12'h123, {3{12'h777}}});
    step(mkOp(0, 1, 0, 1, 0, 1, 2'd0, 3'd0, 12'h000));
    check("R8", {35'd0, rbOe, rbData}, {35'd0, 1'b1, 12'h05A});
    step(mkOp(0, 1, 0, 1, 1, 1, 2'd3, 3'd0, 12'h000));
    check("R8", {35'd0, rbOe, rbData}, {35'd0, 1'b1, 12'h123});
    idle(1);
    check("R9", {35'd0, rbOe, rbData}, 48'd0);

    // R10: clear overrides a simultaneous write
    step(mkOp(0, 0, 1, 0, 1, 0, 2'd0, 3'd0, 12'hFFF));
    idle(2);
    check("R10", rankOut, 48'd0);

    // constrained random traffic checked against the model every step
    for (int n = 0; n < 4000; n++) begin
      o.clr  = ($urandom_range(39) != 0);
      o.cs   = ($urandom_range(5) == 0);
      o.rd   = ($urandom_range(9) != 0);
      o.tr   = ($urandom_range(9) != 0);
      o.ms   = ($urandom_range(9) != 0);
      o.ls   = $urandom_range(1);
      o.addr = 2'($urandom_range(3));
      o.q    = 3'($urandom_range(7));
      o.d    = 12'($urandom());
      step(o);
    end
    idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule